// File: doc/BRIEF.md
# Handheld LCD Scan Timing and Status Interrupt Generator

This block produces the scan timing of a 160x144 handheld-style LCD controller. It counts dots and lines on a dot rate of half the system clock. A single toggling register sets that rate, so it does not follow any CPU speed mode. From the counters it derives the current display phase. It drives one-dot line and frame sync strobes and a simple debug colour pattern to a downstream scan converter.

Software sees five byte-wide registers on a small address/data bus with write and read strobes: a control register, a status register, a vertical scroll value, the current line number and a line-compare value. The line-number register steps to the next line four dots before the search phase begins, not at the line wrap. Four status sources (entry into each of three phases, and a match of line number with the compare value) are gated by enable bits into one status interrupt. A separate interrupt marks the start of vertical blank.

Top module: `lcd_scan_timer`

## Requirements
- R1: `dot_clk_o` is 0 after reset and inverts on every `clk_i` edge. The dot counter advances only on edges where `dot_clk_o` is 1 before the edge, so one dot lasts two system clocks.
- R2: The dot counter runs 0..455 and wraps to 0. On each wrap the line counter increments, running 0..153 and wrapping to 0. This gives 912 system clocks per line and 154 lines per frame.
- R3: The phase code, read in status bits 1:0, is 1 on lines 144..153. On lines 0..143 it is 3 for dots 0..165, 0 for dots 166..372 and 2 for dots 373..455.
- R4: Register 3 (line number) reads the current line for dots 0..368. From dot 369, four dots before the search phase at dot 373, it reads the next line number, where the line after 153 is 0.
- R5: `line_sync_o` is 1 exactly while the dot counter is 455. `frame_sync_o` is 1 exactly while the dot counter is 455 and the line counter is 153.
- R6: For dot < 160 and line < 144: `red_o` is 7 when the line counter equals the compare value and 0 otherwise, `grn_o` is 7 when the line counter is below the scroll value and 0 otherwise, and `blu_o` is 3. Outside that area all three are 0.
- R7: `stat_irq_o` pulses for one clock on the rising edge of any enabled source. The sources and their status enable bits are: phase code becomes 0 (bit 3), becomes 1 (bit 4), becomes 2 (bit 5), and the line-number register becomes equal to the compare value (bit 6). A condition that stays true does not pulse again.
- R8: `vblank_irq_o` pulses for one clock when the line counter becomes 144, once per frame, independent of the enable bits.
- R9: The register addresses are 0 control, 1 status, 2 scroll, 3 line number, 4 compare. After reset the control register is 0x91 and every other stored value is 0. `rdata_o` is 0 when `rd_i` is low or the address is 5..7. A write with `wr_i` high takes effect at the clock edge.
- R10: Status reads as {0, enables[6:3], coincidence flag in bit 2, phase code in bits 1:0}. The coincidence flag is 1 when the line-number register equals the compare value. Writes to status bits 7 and 2:0 are ignored, and writes to the line-number register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, 0 when not reading |
| dot_clk_o | output | 1 | Half-rate dot clock |
| line_sync_o | output | 1 | One-dot line strobe |
| frame_sync_o | output | 1 | One-dot frame strobe |
| red_o | output | 3 | Debug red level |
| grn_o | output | 3 | Debug green level |
| blu_o | output | 2 | Debug blue level |
| stat_irq_o | output | 1 | Combined status interrupt pulse |
| vblank_irq_o | output | 1 | Vertical-blank interrupt pulse |

## Verification
The hardest situations to reach are the frame-level ones. Vertical blank, the frame strobe and the line-number wrap from 153 to 0 at dot 369 occur only once per 140,448 clocks. Another is a compare match that rises because the line-number register stepped early rather than because the compare value was written. The stimulus runs a full frame with a per-cycle reference model. Random writes of compare values below 160, random status enable patterns and random reads land on every line, including vertical blank and the early-step window.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  typedef enum logic [1:0] {
    MODE_HBLANK = 2'd0,
    MODE_VBLANK = 2'd1,
    MODE_SEARCH = 2'd2,
    MODE_DRAW   = 2'd3
  } lcd_mode_e;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_SCY  = 3'd2;
  localparam logic [2:0] A_LY   = 3'd3;
  localparam logic [2:0] A_LYC  = 3'd4;

  localparam logic [7:0] CTRL_RST = 8'h91;
endpackage

// File: rtl/lcd_scan_counter.sv
module lcd_scan_counter
  import lcd_scan_pkg::*;
#(
  parameter int DOTS_PER_LINE   = 456,
  parameter int LINES_PER_FRAME = 154,
  parameter int VIS_LINES       = 144,
  parameter int DRAW_DOTS       = 166,
  parameter int HBLANK_LAST     = 372,
  parameter int LY_LEAD         = 4,
  localparam int DOT_W  = $clog2(DOTS_PER_LINE),
  localparam int LINE_W = $clog2(LINES_PER_FRAME)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              dot_o,
  output logic [DOT_W-1:0]  x_o,
  output logic [LINE_W-1:0] line_o,
  output logic [7:0]        ly_o,
  output lcd_mode_e         mode_o
);
  localparam logic [DOT_W-1:0]  X_LAST  = DOT_W'(DOTS_PER_LINE - 1);
  localparam logic [DOT_W-1:0]  X_LYPRE = DOT_W'(HBLANK_LAST + 1 - LY_LEAD - 1);
  localparam logic [DOT_W-1:0]  X_DRAW  = DOT_W'(DRAW_DOTS);
  localparam logic [DOT_W-1:0]  X_HBL   = DOT_W'(HBLANK_LAST);
  localparam logic [LINE_W-1:0] L_LAST  = LINE_W'(LINES_PER_FRAME - 1);
  localparam logic [LINE_W-1:0] L_VIS   = LINE_W'(VIS_LINES);

  logic              dot_q;
  logic [DOT_W-1:0]  x_q;
  logic [LINE_W-1:0] line_q, line_nxt;
  logic [7:0]        ly_q;

  assign line_nxt = (line_q == L_LAST) ? '0 : line_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dot_q  <= 1'b0;
      x_q    <= '0;
      line_q <= '0;
      ly_q   <= '0;
    end else begin
      dot_q <= ~dot_q;
      if (dot_q) begin
        if (x_q == X_LAST) begin
          x_q    <= '0;
          line_q <= line_nxt;
        end else begin
          x_q <= x_q + 1'b1;
        end
        // visible line number leads the search phase
        if (x_q == X_LYPRE) ly_q <= 8'(line_nxt);
      end
    end
  end

  always_comb begin
    if (line_q >= L_VIS)      mode_o = MODE_VBLANK;
    else if (x_q < X_DRAW)    mode_o = MODE_DRAW;
    else if (x_q <= X_HBL)    mode_o = MODE_HBLANK;
    else                      mode_o = MODE_SEARCH;
  end

  assign dot_o  = dot_q;
  assign x_o    = x_q;
  assign line_o = line_q;
  assign ly_o   = ly_q;

  p_dot_toggle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> dot_q != $past(dot_q));
  p_dot_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_q <= X_LAST);
  p_line_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_q <= L_LAST);
  p_ly_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dot_q && x_q == X_LYPRE) |=> ly_q != $past(ly_q));
endmodule

// File: rtl/lcd_scan_regs.sv
module lcd_scan_regs
  import lcd_scan_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  lcd_mode_e  mode_i,
  input  logic [7:0] ly_i,
  output logic [7:0] scy_o,
  output logic [7:0] lyc_o,
  output logic [3:0] en_o,
  output logic       coinc_o,
  output logic [7:0] rdata_o
);
  logic [7:0] ctrl_q, scy_q, lyc_q;
  logic [3:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      scy_q  <= '0;
      lyc_q  <= '0;
      en_q   <= '0;
    end else if (wr_i) begin
      unique case (addr_i)
        A_CTRL:  ctrl_q <= wdata_i;
        A_STAT:  en_q   <= wdata_i[6:3];
        A_SCY:   scy_q  <= wdata_i;
        A_LYC:   lyc_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  assign coinc_o = (ly_i == lyc_q);

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        A_CTRL:  rdata_o = ctrl_q;
        A_STAT:  rdata_o = {1'b0, en_q, coinc_o, mode_i};
        A_SCY:   rdata_o = scy_q;
        A_LY:    rdata_o = ly_i;
        A_LYC:   rdata_o = lyc_q;
        default: rdata_o = '0;
      endcase
    end
  end

  assign scy_o = scy_q;
  assign lyc_o = lyc_q;
  assign en_o  = en_q;

  p_ly_write_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_LY) |=> $stable(lyc_q) && $stable(scy_q) && $stable(en_q) && $stable(ctrl_q));
endmodule

// File: rtl/lcd_scan_irq.sv
module lcd_scan_irq
  import lcd_scan_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  lcd_mode_e  mode_i,
  input  logic       coinc_i,
  input  logic [3:0] en_i,
  output logic       stat_irq_o,
  output logic       vblank_irq_o
);
  // source order matches enable bits 3..6
  logic [3:0] cond, prev_q, rise;

  assign cond = {coinc_i, mode_i == MODE_SEARCH, mode_i == MODE_VBLANK, mode_i == MODE_HBLANK};

  // history primed with the reset-state conditions (line 0 equals compare 0)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 4'b1000;
    else         prev_q <= cond;
  end

  assign rise         = cond & ~prev_q;
  assign stat_irq_o   = |(rise & en_i);
  assign vblank_irq_o = rise[1];

  p_vbl_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_irq_o |=> !vblank_irq_o);
  p_irq_needs_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == 4'b0000) |-> !stat_irq_o);
endmodule

// File: rtl/lcd_scan_pixel.sv
module lcd_scan_pixel #(
  parameter int DOTS_PER_LINE   = 456,
  parameter int LINES_PER_FRAME = 154,
  parameter int VIS_LINES       = 144,
  parameter int VIS_DOTS        = 160,
  localparam int DOT_W  = $clog2(DOTS_PER_LINE),
  localparam int LINE_W = $clog2(LINES_PER_FRAME)
) (
  input  logic [DOT_W-1:0]  x_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [7:0]        lyc_i,
  input  logic [7:0]        scy_i,
  output logic              line_sync_o,
  output logic              frame_sync_o,
  output logic [2:0]        red_o,
  output logic [2:0]        grn_o,
  output logic [1:0]        blu_o
);
  localparam logic [DOT_W-1:0]  X_LAST = DOT_W'(DOTS_PER_LINE - 1);
  localparam logic [DOT_W-1:0]  X_VIS  = DOT_W'(VIS_DOTS);
  localparam logic [LINE_W-1:0] L_LAST = LINE_W'(LINES_PER_FRAME - 1);
  localparam logic [LINE_W-1:0] L_VIS  = LINE_W'(VIS_LINES);

  logic active;

  assign line_sync_o  = (x_i == X_LAST);
  assign frame_sync_o = line_sync_o && (line_i == L_LAST);
  assign active       = (x_i < X_VIS) && (line_i < L_VIS);

  always_comb begin
    red_o = '0;
    grn_o = '0;
    blu_o = '0;
    if (active) begin
      red_o = (8'(line_i) == lyc_i) ? 3'b111 : 3'b000;
      grn_o = (8'(line_i) <  scy_i) ? 3'b111 : 3'b000;
      blu_o = 2'b11;
    end
  end
endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
  import lcd_scan_pkg::*;
#(
  parameter int DOTS_PER_LINE   = 456,
  parameter int LINES_PER_FRAME = 154,
  parameter int VIS_LINES       = 144,
  parameter int VIS_DOTS        = 160,
  parameter int DRAW_DOTS       = 166,
  parameter int HBLANK_LAST     = 372,
  parameter int LY_LEAD         = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       wr_i,
  input  logic       rd_i,
  output logic [7:0] rdata_o,
  output logic       dot_clk_o,
  output logic       line_sync_o,
  output logic       frame_sync_o,
  output logic [2:0] red_o,
  output logic [2:0] grn_o,
  output logic [1:0] blu_o,
  output logic       stat_irq_o,
  output logic       vblank_irq_o
);
  localparam int DOT_W  = $clog2(DOTS_PER_LINE);
  localparam int LINE_W = $clog2(LINES_PER_FRAME);

  logic [DOT_W-1:0]  x;
  logic [LINE_W-1:0] line;
  logic [7:0]        ly, scy, lyc;
  logic [3:0]        en;
  logic              coinc;
  lcd_mode_e         mode;

  lcd_scan_counter #(
    .DOTS_PER_LINE(DOTS_PER_LINE), .LINES_PER_FRAME(LINES_PER_FRAME),
    .VIS_LINES(VIS_LINES), .DRAW_DOTS(DRAW_DOTS),
    .HBLANK_LAST(HBLANK_LAST), .LY_LEAD(LY_LEAD)
  ) u_cnt (
    .clk_i, .rst_ni, .dot_o(dot_clk_o), .x_o(x), .line_o(line),
    .ly_o(ly), .mode_o(mode)
  );

  lcd_scan_regs u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .wr_i, .rd_i,
    .mode_i(mode), .ly_i(ly), .scy_o(scy), .lyc_o(lyc), .en_o(en),
    .coinc_o(coinc), .rdata_o
  );

  lcd_scan_irq u_irq (
    .clk_i, .rst_ni, .mode_i(mode), .coinc_i(coinc), .en_i(en),
    .stat_irq_o, .vblank_irq_o
  );

  lcd_scan_pixel #(
    .DOTS_PER_LINE(DOTS_PER_LINE), .LINES_PER_FRAME(LINES_PER_FRAME),
    .VIS_LINES(VIS_LINES), .VIS_DOTS(VIS_DOTS)
  ) u_pix (
    .x_i(x), .line_i(line), .lyc_i(lyc), .scy_i(scy),
    .line_sync_o, .frame_sync_o, .red_o, .grn_o, .blu_o
  );

  p_frame_in_line_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_sync_o |-> line_sync_o);
  p_vbl_line_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_irq_o |-> (line == LINE_W'(VIS_LINES)) && (x == '0));
  p_search_after_ly_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mode == MODE_SEARCH)) |-> (ly != 8'(line)));
endmodule

// File: tb/lcd_scan_timer_test.sv
module lcd_scan_timer_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] rdata_o;
  logic       dot_clk_o, line_sync_o, frame_sync_o, stat_irq_o, vblank_irq_o;
  logic [2:0] red_o, grn_o;
  logic [1:0] blu_o;

  lcd_scan_timer uut (.*);

  always #5 clk_i = ~clk_i;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  // reference model state
  int m_dot = 0, m_x = 0, m_line = 0;
  int m_ctrl = 'h91, m_scy = 0, m_lyc = 0, m_en = 0;
  int prev_cond = 'b1000;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_dot = 0; m_x = 0; m_line = 0;
      m_ctrl = 'h91; m_scy = 0; m_lyc = 0; m_en = 0;
      prev_cond = 'b1000;
    end else begin
      if (wr_i) begin
        case (addr_i)
          3'd0: m_ctrl = wdata_i;
          3'd1: m_en   = (wdata_i >> 3) & 'hF;
          3'd2: m_scy  = wdata_i;
          3'd4: m_lyc  = wdata_i;
          default: ;
        endcase
      end
      if (m_dot == 1) begin
        if (m_x == 455) begin
          m_x = 0;
          m_line = (m_line == 153) ? 0 : m_line + 1;
        end else m_x = m_x + 1;
      end
      m_dot = 1 - m_dot;
    end
  end

  function automatic int nxt_line(int l);
    return (l == 153) ? 0 : l + 1;
  endfunction
  function automatic int exp_mode(int x, int l);
    if (l >= 144) return 1;
    if (x <= 165) return 3;
    if (x <= 372) return 0;
    return 2;
  endfunction
  function automatic int exp_ly(int x, int l);
    return (x >= 369) ? nxt_line(l) : l;
  endfunction
  function automatic int exp_coinc();
    return (exp_ly(m_x, m_line) == m_lyc) ? 1 : 0;
  endfunction
  function automatic int exp_rdata(int a, bit rd);
    if (!rd) return 0;
    case (a)
      0: return m_ctrl;
      1: return (m_en << 3) | (exp_coinc() << 2) | exp_mode(m_x, m_line);
      2: return m_scy;
      3: return exp_ly(m_x, m_line);
      4: return m_lyc;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  int cyc = 0, last_ls = -1, ls_count = 0, frames = 0;
  bit ls_prev = 1'b0, fs_prev = 1'b0;

  task automatic step(input bit wr, input bit rd, input int a, input int d);
    int cond, act, mode;
    @(negedge clk_i);
    wr_i = wr; rd_i = rd; addr_i = 3'(a); wdata_i = 8'(d);
    #1;
    cyc++;
    chk("R1 dot clock", dot_clk_o, m_dot);
    chk("R5 line sync", line_sync_o, (m_x == 455) ? 1 : 0);
    chk("R5 frame sync", frame_sync_o, (m_x == 455 && m_line == 153) ? 1 : 0);
    act = (m_x < 160 && m_line < 144) ? 1 : 0;
    chk("R6 red", red_o, (act && m_line == m_lyc) ? 7 : 0);
    chk("R6 green", grn_o, (act && m_line < m_scy) ? 7 : 0);
    chk("R6 blue", blu_o, act ? 3 : 0);
    mode = exp_mode(m_x, m_line);
    cond = (exp_coinc() << 3) | ((mode == 2) << 2) | ((mode == 1) << 1) | (mode == 0 ? 1 : 0);
    chk("R7 status irq", stat_irq_o, ((cond & ~prev_cond & m_en) != 0) ? 1 : 0);
    chk("R8 vblank irq", vblank_irq_o, ((cond & ~prev_cond & 2) != 0) ? 1 : 0);
    prev_cond = cond;
    case (a)
      1: chk("R3/R10 status read", rdata_o, exp_rdata(a, rd));
      3: chk("R4 line number read", rdata_o, exp_rdata(a, rd));
      default: chk("R9 register read", rdata_o, exp_rdata(a, rd));
    endcase
    if (line_sync_o && !ls_prev) begin
      ls_count++;
      if (last_ls >= 0) chk("R2 line period", cyc - last_ls, 912);
      last_ls = cyc;
    end
    if (frame_sync_o && !fs_prev) begin
      frames++;
      if (frames == 1) chk("R2 lines per frame", ls_count, 154);
    end
    ls_prev = line_sync_o;
    fs_prev = frame_sync_o;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R9 reset values
    step(0, 1, 0, 0);
    step(0, 1, 1, 0);
    step(0, 1, 4, 0);
    // R10: enable all sources, low bits and bit 7 ignored
    step(1, 0, 1, 'hFF);
    step(0, 1, 1, 0);
    // R10: line-number write ignored
    step(1, 0, 3, 'h55);
    step(0, 1, 3, 0);
    step(1, 0, 4, 2);
    step(1, 0, 2, 60);
    step(0, 1, 6, 0);
    for (int i = 0; i < 141000; i++) begin
      int r = int'($urandom % 1000);
      if (r < 3) begin
        int a = int'($urandom % 5);
        int d = (a == 4) ? int'($urandom % 160) : int'($urandom % 256);
        step(1, 0, a, d);
      end else if (r < 600) begin
        step(0, 1, int'($urandom % 8), 0);
      end else begin
        step(0, 0, int'($urandom % 8), 0);
      end
    end
    chk("R5 frame seen", (frames >= 1) ? 1 : 0, 1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(190000 * 10);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule